// File: doc/BRIEF.md
# Indirect Serial Management Access Engine

This block gives a host indirect access to two slow serial devices: the management register file of an Ethernet PHY, reached over a two-wire clock/data management bus, and a 16-bit-word serial EEPROM, reached over a three-wire chip-select/clock/data bus. The host never drives the serial lines itself. It loads a target address and a 16-bit data word into byte registers, then writes a command into the control register. The engine runs the whole serial sequence for the selected target and raises a busy flag for the duration. After a read, the fetched word appears in the data registers.

The host side is a plain byte-wide register port with four locations. Writes complete in one clock and reads are combinational, so there is no handshake and no back-pressure. The host must poll the busy flag before it touches the registers again. Both serial clocks come from the system clock through a divider set by `CLK_DIV`, which gives the number of system clocks per serial half-period.

Top module: `serial_mgmt_engine`

## Requirements
- R1: After reset every register reads 0, busy is 0, the management clock and the EEPROM chip select are low, and the management data driver is disabled.
- R2: Offset 1 holds the target address in bits 5:0 (bits 7:6 read 0). Offset 2 holds data bits 7:0 and offset 3 holds data bits 15:8. All three read back what was written.
- R3: At offset 0 the control register has bit 0 = read, bit 1 = write, bit 2 = target (1 = PHY, 0 = EEPROM) and bit 7 = busy (read only). When a bit is 1 in both bit 1 and bit 0, the write takes precedence. A PHY write drives 64 bits MSB first on the data line: 32 ones, 01, opcode 01, the PHY address (parameter `PHY_ADDR`), address bits 4:0, 10, then the 16 data bits.
- R4: A PHY read drives 32 ones, 01, opcode 10, the PHY address and the register address (46 bits). It then releases the data line for the two turnaround bits and the 16 data bits, samples the 16 data bits MSB first, and loads them into the data registers.
- R5: The management clock period is 2*`CLK_DIV` system clocks. The data line changes only when the clock falls, so the device samples it on the rising edge.
- R6: An EEPROM read holds chip select high for 25 clock pulses. It sends 1, opcode 10 and the 6-bit word address, then shifts in 16 data bits MSB first, sampled on the rising clock edge, and loads them into the data registers.
- R7: An EEPROM write first sends the 9-bit write-enable frame 1 00 110000. It then drops chip select for one clock period and sends a 25-bit frame: 1, opcode 01, the address, then the 16 data bits. The data line changes only while the clock is low.
- R8: Busy reads 1 from the clock after a starting command write until the access ends, then 0. Only a control write can make it rise.
- R9: A command written while busy is set is stored in the control register but starts no access, neither then nor when the current access ends.
- R10: An access starts only when a command bit goes from 0 to 1 on a control write. The host must clear the bit before it can issue the same command again.
- R11: An access runs only on the selected target. The other bus stays idle: while the EEPROM chip select is high, the management clock is low and the management data driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mdc_o | output | 1 | Management bus clock |
| mdo_o | output | 1 | Management data out |
| mdo_oe_o | output | 1 | Management data output enable |
| mdi_i | input | 1 | Management data in |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Data to the EEPROM |
| ee_do_i | input | 1 | Data from the EEPROM |

## Verification
The bench places device models on both buses. These models log every bit clocked in and return known words on reads. A frame that is off by one bit, has a swapped opcode, has a bad turnaround release or misses the write-enable frame therefore shows up as a wrong captured pattern or a wrong data register value. The bench writes a second command during an access and re-writes a command that is still set. A design that latched commands on level instead of on a fresh edge would start an extra frame that the models count. The bench measures the clock period between two rising edges, which catches a divider that is off by one. It also checks that the bus that was not selected carries no activity.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_ADDR = 2'd1;
  localparam logic [1:0] OFS_DLO  = 2'd2;
  localparam logic [1:0] OFS_DHI  = 2'd3;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 6;
  typedef enum logic [1:0] {UW_IDLE, UW_EWEN, UW_GAP, UW_XFER} uw_state_t;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;
  logic wrap;

  assign wrap   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !sclk_o;
  assign fall_o = wrap && sclk_o;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        start_i,
  input  logic        is_wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdi_i,
  output logic        active_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdo_o,
  output logic        oe_o
);
  localparam int FRAME    = PRE_LEN + 32;
  localparam int IW       = $clog2(FRAME);
  localparam int TA_IDX   = PRE_LEN + 14;
  localparam int DATA_IDX = PRE_LEN + 16;

  logic [FRAME-1:0] tx_q;
  logic [IW-1:0]    idx_q;
  logic             wr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
      mdo_o    <= 1'b1;
      oe_o     <= 1'b0;
      tx_q     <= '0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_o) begin
        active_o <= 1'b1;
        wr_q     <= is_wr_i;
        idx_q    <= '0;
        tx_q     <= {{PRE_LEN{1'b1}}, 2'b01, (is_wr_i ? 2'b01 : 2'b10), phy_i, reg_i,
                     (is_wr_i ? 2'b10 : 2'b00), (is_wr_i ? wdata_i : 16'h0000)};
        mdo_o    <= 1'b1;
        oe_o     <= 1'b1;
      end else if (active_o) begin
        if (rise_i && !wr_q && idx_q >= IW'(DATA_IDX))
          rdata_o <= {rdata_o[14:0], mdi_i};
        if (fall_i) begin
          if (idx_q == IW'(FRAME - 1)) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
            mdo_o    <= 1'b1;
            oe_o     <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            tx_q  <= tx_q << 1;
            mdo_o <= tx_q[FRAME-2];
            oe_o  <= wr_q || (idx_q < IW'(TA_IDX - 1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
  import mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              is_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              active_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              dout_o
);
  localparam int HDR   = 3 + ADDR_W;
  localparam int FRAME = HDR + WORD_W;
  localparam int IW    = $clog2(FRAME);

  uw_state_t         st_q;
  logic [FRAME-1:0]  tx_q;
  logic [IW-1:0]     idx_q, last_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wd_q;

  assign active_o = (st_q != UW_IDLE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= UW_IDLE;
      tx_q    <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      cs_o    <= 1'b0;
      dout_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        UW_IDLE: if (start_i) begin
          wr_q   <= is_wr_i;
          addr_q <= addr_i;
          wd_q   <= wdata_i;
          idx_q  <= '0;
          cs_o   <= 1'b1;
          dout_o <= 1'b1;
          if (is_wr_i) begin
            st_q   <= UW_EWEN;
            tx_q   <= {3'b100, 2'b11, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
            last_q <= IW'(HDR - 1);
          end else begin
            st_q   <= UW_XFER;
            tx_q   <= {3'b110, addr_i, {WORD_W{1'b0}}};
            last_q <= IW'(FRAME - 1);
          end
        end
        UW_GAP: if (fall_i) begin
          st_q   <= UW_XFER;
          cs_o   <= 1'b1;
          dout_o <= 1'b1;
          idx_q  <= '0;
          last_q <= IW'(FRAME - 1);
          tx_q   <= {3'b101, addr_q, wd_q};
        end
        default: begin
          if (rise_i && st_q == UW_XFER && !wr_q && idx_q >= IW'(HDR))
            rdata_o <= {rdata_o[WORD_W-2:0], din_i};
          if (fall_i) begin
            if (idx_q == last_q) begin
              cs_o   <= 1'b0;
              dout_o <= 1'b0;
              if (st_q == UW_EWEN) st_q <= UW_GAP;
              else begin
                st_q   <= UW_IDLE;
                done_o <= 1'b1;
              end
            end else begin
              idx_q  <= idx_q + 1'b1;
              tx_q   <= tx_q << 1;
              dout_o <= tx_q[FRAME-2];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_mgmt_engine.sv
module serial_mgmt_engine
  import mgmt_pkg::*;
#(
  parameter int         CLK_DIV  = 2,
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       mdc_o,
  output logic       mdo_o,
  output logic       mdo_oe_o,
  input  logic       mdi_i,
  output logic       ee_cs_o,
  output logic       ee_sk_o,
  output logic       ee_di_o,
  input  logic       ee_do_i
);
  logic              cmd_rd_q, cmd_wr_q, sel_phy_q, busy_q, op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              ctrl_wr, new_cmd, start, start_wr;
  logic              sclk, rise, fall;
  logic              phy_act, phy_done, ee_act, ee_done;
  logic [WORD_W-1:0] phy_rd, ee_rd;

  assign ctrl_wr  = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign new_cmd  = (reg_wdata_i[0] && !cmd_rd_q) || (reg_wdata_i[1] && !cmd_wr_q);
  assign start    = ctrl_wr && !busy_q && new_cmd;
  assign start_wr = reg_wdata_i[1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_rd_q  <= 1'b0;
      cmd_wr_q  <= 1'b0;
      sel_phy_q <= 1'b0;
      busy_q    <= 1'b0;
      op_wr_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        cmd_rd_q  <= reg_wdata_i[0];
        cmd_wr_q  <= reg_wdata_i[1];
        sel_phy_q <= reg_wdata_i[2];
      end
      if (reg_wr_i && reg_addr_i == OFS_ADDR) addr_q <= reg_wdata_i[ADDR_W-1:0];
      if (reg_wr_i && reg_addr_i == OFS_DLO)  data_q[7:0]  <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == OFS_DHI)  data_q[15:8] <= reg_wdata_i;
      if (start) begin
        busy_q  <= 1'b1;
        op_wr_q <= start_wr;
      end else if (phy_done || ee_done) begin
        busy_q <= 1'b0;
        if (!op_wr_q) data_q <= phy_done ? phy_rd : ee_rd;
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_CTRL: reg_rdata_o = {busy_q, 4'b0000, sel_phy_q, cmd_wr_q, cmd_rd_q};
      OFS_ADDR: reg_rdata_o = {{(8-ADDR_W){1'b0}}, addr_q};
      OFS_DLO:  reg_rdata_o = data_q[7:0];
      default:  reg_rdata_o = data_q[15:8];
    endcase
  end

  sclk_gen #(.HALF(CLK_DIV)) clk_gen_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(phy_act || ee_act),
    .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
  );

  mdio_seq #(.PRE_LEN(32)) mdio_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start && reg_wdata_i[2]), .is_wr_i(start_wr),
    .phy_i(PHY_ADDR), .reg_i(addr_q[4:0]), .wdata_i(data_q),
    .rise_i(rise), .fall_i(fall), .mdi_i(mdi_i),
    .active_o(phy_act), .done_o(phy_done), .rdata_o(phy_rd),
    .mdo_o(mdo_o), .oe_o(mdo_oe_o)
  );

  uwire_seq uw_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start && !reg_wdata_i[2]), .is_wr_i(start_wr),
    .addr_i(addr_q), .wdata_i(data_q), .rise_i(rise), .fall_i(fall), .din_i(ee_do_i),
    .active_o(ee_act), .done_o(ee_done), .rdata_o(ee_rd),
    .cs_o(ee_cs_o), .dout_o(ee_di_o)
  );

  assign mdc_o   = sclk && phy_act;
  assign ee_sk_o = sclk && ee_cs_o;
endmodule

// File: rtl/mgmt_chk.sv
module mgmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       busy,
  input logic       mdc,
  input logic       mdo,
  input logic       mdo_oe,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di
);
  // R5
  mdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(mdc) |-> $stable(mdo));
  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mdo_oe) |-> $fell(mdc));
  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd0));
  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> (!mdc && !mdo_oe));
  // R7
  ee_di_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ee_cs && $past(ee_cs) && !$fell(ee_sk)) |-> $stable(ee_di));
endmodule

bind serial_mgmt_engine mgmt_chk chk_i (
  .clk(clk_i), .rst(rst_i), .reg_wr(reg_wr_i), .reg_addr(reg_addr_i), .busy(busy_q),
  .mdc(mdc_o), .mdo(mdo_o), .mdo_oe(mdo_oe_o), .ee_cs(ee_cs_o), .ee_sk(ee_sk_o), .ee_di(ee_di_o)
);

// File: tb/serial_mgmt_engine_tb_top.sv
module serial_mgmt_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int DIV = 2;
  localparam logic [4:0] PHYA = 5'h01;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic mdc, mdo, mdo_oe, ee_cs, ee_sk, ee_di;
  logic mdi = 1'b0, ee_do = 1'b0;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_mgmt_engine #(.CLK_DIV(DIV), .PHY_ADDR(PHYA)) dut_i (
    .clk_i(clk), .rst_i(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc), .mdo_o(mdo),
    .mdo_oe_o(mdo_oe), .mdi_i(mdi), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk),
    .ee_di_o(ee_di), .ee_do_i(ee_do)
  );

  // PHY model
  int ph_rises = 0;
  logic [63:0] ph_cap = '0, ph_oe = '0;
  logic [15:0] ph_data = '0;
  time ph_t0 = 0, ph_t1 = 0;
  always @(posedge mdc) begin
    ph_cap = {ph_cap[62:0], mdo};
    ph_oe  = {ph_oe[62:0], mdo_oe};
    if (ph_rises == 0) ph_t0 = $time;
    if (ph_rises == 1) ph_t1 = $time;
    ph_rises = ph_rises + 1;
  end
  always @(negedge mdc) begin
    int r;
    r = ph_rises - 1;
    mdi = (r >= 47 && r <= 62) ? ph_data[15-(r-47)] : 1'b0;
  end

  // EEPROM model
  int ee_rises = 0, ee_nfr = 0;
  logic [31:0] ee_cap = '0;
  int ee_len[4];
  logic [31:0] ee_bits[4];
  logic [15:0] ee_data = '0;
  always @(posedge ee_sk) begin
    ee_cap = {ee_cap[30:0], ee_di};
    ee_rises = ee_rises + 1;
  end
  always @(negedge ee_sk) begin
    int r;
    r = ee_rises - 1;
    ee_do = (r >= 8 && r <= 23) ? ee_data[15-(r-8)] : 1'b0;
  end
  always @(negedge ee_cs) begin
    if (ee_nfr < 4) begin
      ee_len[ee_nfr]  = ee_rises;
      ee_bits[ee_nfr] = ee_cap;
    end
    ee_nfr = ee_nfr + 1;
    ee_rises = 0;
    ee_cap = '0;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd0, v);
      if (!v[7]) return;
    end
    check(0, "R8 busy never cleared", 1, 0);
  endtask

  task automatic clear_models();
    ph_rises = 0; ph_cap = '0; ph_oe = '0;
    ee_nfr = 0; ee_rises = 0; ee_cap = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      check(v == 8'h00, "R1 register reset", v, 0);
    end
    check({mdc, mdo_oe, ee_cs} == 3'b000, "R1 bus idle", {mdc, mdo_oe, ee_cs}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    reg_write(2'd1, 8'hEA); reg_write(2'd2, 8'h34); reg_write(2'd3, 8'h12);
    reg_read(2'd1, v); check(v == 8'h2A, "R2 addr readback", v, 8'h2A);
    reg_read(2'd2, v); check(v == 8'h34, "R2 data low", v, 8'h34);
    reg_read(2'd3, v); check(v == 8'h12, "R2 data high", v, 8'h12);
  endtask

  task automatic t_phy_write();
    logic [7:0] v;
    logic [63:0] exp;
    clear_models();
    reg_write(2'd1, 8'h05); reg_write(2'd2, 8'hEF); reg_write(2'd3, 8'hBE);
    reg_write(2'd0, 8'h06);
    reg_read(2'd0, v); check(v[7] == 1'b1, "R8 busy after issue", v, 8'h86);
    wait_idle();
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, PHYA, 5'd5, 2'b10, 16'hBEEF};
    check(ph_rises == 64, "R3 PHY write length", 64'(ph_rises), 64);
    check(ph_cap == exp, "R3 PHY write frame", ph_cap, exp);
    check(ph_oe == '1, "R3 PHY write drive", ph_oe, '1);
    check(ph_t1 - ph_t0 == 2*DIV*CLK_P, "R5 MDC period", 64'(ph_t1 - ph_t0), 2*DIV*CLK_P);
    check(ee_nfr == 0, "R11 EEPROM idle on PHY op", 64'(ee_nfr), 0);
    reg_write(2'd0, 8'h04);
  endtask

  task automatic t_phy_read();
    logic [7:0] lo, hi;
    clear_models();
    ph_data = 16'hA5C3;
    reg_write(2'd1, 8'h11);
    reg_write(2'd0, 8'h05);
    wait_idle();
    check(ph_cap[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, PHYA, 5'h11}, "R4 PHY read header",
          64'(ph_cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, PHYA, 5'h11}));
    check(ph_oe == 64'hFFFF_FFFF_FFFC_0000, "R4 turnaround release", ph_oe, 64'hFFFF_FFFF_FFFC_0000);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    check({hi, lo} == 16'hA5C3, "R4 PHY read data", {hi, lo}, 16'hA5C3);
  endtask

  task automatic t_ee_read();
    logic [7:0] lo, hi;
    reg_write(2'd0, 8'h00);
    clear_models();
    ee_data = 16'h5A17;
    reg_write(2'd1, 8'h2B);
    reg_write(2'd0, 8'h01);
    wait_idle();
    check(ee_nfr == 1 && ee_len[0] == 25, "R6 EEPROM read length", 64'(ee_len[0]), 25);
    check(ee_bits[0][24:16] == 9'b110101011, "R6 EEPROM read header",
          64'(ee_bits[0][24:16]), 64'(9'b110101011));
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    check({hi, lo} == 16'h5A17, "R6 EEPROM read data", {hi, lo}, 16'h5A17);
    check(ph_rises == 0, "R11 PHY idle on EEPROM op", 64'(ph_rises), 0);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_ee_write();
    clear_models();
    reg_write(2'd1, 8'h07); reg_write(2'd2, 8'h34); reg_write(2'd3, 8'h12);
    reg_write(2'd0, 8'h02);
    wait_idle();
    check(ee_nfr == 2, "R7 EEPROM write frame count", 64'(ee_nfr), 2);
    check(ee_len[0] == 9 && ee_bits[0][8:0] == 9'b100110000, "R7 write-enable frame",
          64'(ee_bits[0][8:0]), 64'(9'b100110000));
    check(ee_len[1] == 25 && ee_bits[1][24:0] == {3'b101, 6'h07, 16'h1234}, "R7 write frame",
          64'(ee_bits[1][24:0]), 64'({3'b101, 6'h07, 16'h1234}));
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    clear_models();
    reg_write(2'd0, 8'h05);
    reg_write(2'd0, 8'h02);
    wait_idle();
    repeat (60) @(negedge clk);
    reg_read(2'd0, v);
    check(v == 8'h02, "R9 stored but idle", v, 8'h02);
    check(ee_nfr == 0 && ph_rises == 64, "R9 no second access", 64'(ee_nfr), 0);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_edge_only();
    logic [7:0] v;
    reg_write(2'd0, 8'h05);
    wait_idle();
    clear_models();
    reg_write(2'd0, 8'h05);
    repeat (40) @(negedge clk);
    reg_read(2'd0, v);
    check(v[7] == 1'b0 && ph_rises == 0, "R10 held bit no restart", 64'(ph_rises), 0);
    reg_write(2'd0, 8'h04);
    reg_write(2'd0, 8'h05);
    reg_read(2'd0, v);
    check(v[7] == 1'b1, "R10 restart after clear", v, 8'h85);
    wait_idle();
    check(ph_rises == 64, "R10 restarted frame", 64'(ph_rises), 64);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_phy_write();
    t_phy_read();
    t_ee_read();
    t_ee_write();
    t_busy_ignore();
    t_edge_only();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule